// File: doc/BRIEF.md
# Rotate-then-Insert Bit-Field Unit

This unit is a single-stage registered datapath that performs a family of three bit-field merge operations on 64-bit words. Each operation rotates a source word to the left. It then picks a contiguous run of bits from the rotated word and writes that run into a copy of a destination word's old value. The run is given by a start index and an end index, with bit 0 as the most significant bit, and it may wrap around past the last bit. An execution stage hands the unit a secondary opcode, the two operands, three 8-bit immediates (start, end and rotate) and a valid strobe. Exactly one clock later it receives the merged word and a valid strobe.

One variant works over the whole 64-bit word. Two variants confine the insertion to the upper 32-bit half or to the lower 32-bit half, and they always keep the other half intact. A flag in the top bit of the end immediate selects between two ways of treating the destination bits outside the run: keep them, or clear them within the working partition. Only the full-width variant produces a condition code, which classifies the signed result. An unknown opcode raises an illegal-operation pulse, and the destination passes through unchanged.

Top module: `rotins_unit`

## Requirements
- R1: `out_valid` equals `in_valid` one clock later. While `rst_n` is low at a rising edge, `out_valid`, `cc_valid`, `illegal_op`, `result` and `cc` are all cleared to 0.
- R2: Before selection, the source is rotated left by `imm_rot` modulo 64, so only bits 5:0 of `imm_rot` matter. For opcode 0x55 with start 0 and end 63, the result equals the rotated source.
- R3: When the start index is not greater than the end index, the inserted bits are big-endian positions start through end inclusive, where position p is bit 63-p of the word.
- R4: When the start index is greater than the end index, the selection wraps. It covers positions start through the last position of the partition, plus positions from the first position of the partition through end.
- R5: Opcode 0x55 (full width) takes its start index from `imm_start[5:0]` and its end index from `imm_end[5:0]`, over positions 0..63. Bits 7:6 of `imm_start` and bit 6 of `imm_end` have no effect.
- R6: Opcode 0x5D (upper half) takes each index from bits 4:0 of its immediate, relative to positions 0..31. Result bits 31:0 always equal the old destination.
- R7: Opcode 0x51 (lower half) takes each index from bits 4:0 of its immediate, relative to positions 32..63. Result bits 63:32 always equal the old destination.
- R8: With `imm_end[7]` = 1, destination bits inside the working partition that are not selected become 0. With `imm_end[7]` = 0, they keep their old value. In both cases, bits outside the partition keep their old value.
- R9: Opcode 0x55 raises `cc_valid` with `out_valid` and loads `cc` from the signed 64-bit result: 0 for zero, 1 for negative, 2 for positive.
- R10: Opcodes 0x5D and 0x51 keep `cc_valid` low and leave `cc` unchanged.
- R11: Any other opcode raises `illegal_op` for one cycle with `out_valid`. The result equals the old destination, `cc_valid` stays low and `cc` is unchanged.
- R12: In a cycle where `in_valid` is low, `result` and `cc` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation request strobe |
| opcode | input | 8 | Secondary opcode selecting the variant |
| src | input | 64 | Source word to rotate |
| dst_old | input | 64 | Old destination value |
| imm_start | input | 8 | Start index immediate |
| imm_end | input | 8 | End index immediate; bit 7 is the clear-unselected flag |
| imm_rot | input | 8 | Rotate-left amount immediate |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Merged word |
| cc | output | 2 | Condition code (0 zero, 1 negative, 2 positive) |
| cc_valid | output | 1 | Condition code updated this cycle |
| illegal_op | output | 1 | Unknown opcode pulse |

## Verification
The bench builds the unit with its default parameters: a 64-bit word and 8-bit immediates. At that size every start and end pair for every variant can be swept, with both settings of the clear flag, which gives full coverage of both wrap and non-wrap mask shapes. All 256 rotate codes are applied to a full-width pass-through selection, and all 256 opcode values are tried so that every unknown code is seen. Expected results come from a per-bit position model that applies the requirement text directly.

// File: rtl/rotins_pkg.sv
// Package: shared opcode values, variant and condition-code types.
// Assumes the secondary opcode is a single byte.
package rotins_pkg;

    localparam logic [7:0] OP_FULL = 8'h55;
    localparam logic [7:0] OP_HIGH = 8'h5D;
    localparam logic [7:0] OP_LOW  = 8'h51;

    typedef enum logic [1:0] {
        VAR_FULL = 2'd0,
        VAR_HIGH = 2'd1,
        VAR_LOW  = 2'd2,
        VAR_NONE = 2'd3
    } variant_e;

    typedef enum logic [1:0] {
        CC_ZERO = 2'd0,
        CC_NEG  = 2'd1,
        CC_POS  = 2'd2
    } ccode_e;

    // Map a secondary opcode onto the variant it selects
    function automatic variant_e decode_op(input logic [7:0] op);
        case (op)
            OP_FULL: return VAR_FULL;
            OP_HIGH: return VAR_HIGH;
            OP_LOW:  return VAR_LOW;
            default: return VAR_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rotins_rotator.sv
// Module: rotins_rotator
// Logarithmic barrel rotator that rotates left by amt.
// Assumes DATA_W is a power of two; amt is already reduced modulo DATA_W.
module rotins_rotator #(
    parameter int DATA_W = 64,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SH_W-1:0]   amt,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] stage [SH_W+1];

    assign stage[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        // Rotate by 2**k when the matching amount bit is set
        assign stage[k+1] = amt[k]
            ? {stage[k][DATA_W-1-STEP:0], stage[k][DATA_W-1 -: STEP]}
            : stage[k];
    end

    assign dout = stage[SH_W];

endmodule

// File: rtl/rotins_maskgen.sv
// Module: rotins_maskgen
// Builds the selection mask and the keep mask for one variant.
// Assumes big-endian bit positions (position 0 is the MSB). VAR_NONE yields
// an empty selection and a full keep mask, so the destination passes through.
module rotins_maskgen
    import rotins_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(DATA_W),
    localparam int HALF  = DATA_W / 2
) (
    input  variant_e          variant,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [IDX_W-1:0]  end_idx,
    input  logic              zero_rest,
    output logic [DATA_W-1:0] sel_mask,
    output logic [DATA_W-1:0] keep_mask
);

    localparam logic [IDX_W-1:0] HALF_LIM = IDX_W'(HALF - 1);

    logic [DATA_W-1:0] part_mask;
    logic [DATA_W-1:0] tail_mask;
    logic [IDX_W-1:0]  s_idx;
    logic [IDX_W-1:0]  e_idx;

    // Choose the partition and reduce the indices for the variant
    always_comb begin
        case (variant)
            VAR_FULL: begin
                part_mask = '1;
                s_idx     = start_idx;
                e_idx     = end_idx;
            end
            VAR_HIGH: begin
                part_mask = {{HALF{1'b1}}, {HALF{1'b0}}};
                s_idx     = start_idx & HALF_LIM;
                e_idx     = end_idx & HALF_LIM;
            end
            VAR_LOW: begin
                part_mask = {{HALF{1'b0}}, {HALF{1'b1}}};
                s_idx     = start_idx & HALF_LIM;
                e_idx     = end_idx & HALF_LIM;
            end
            default: begin
                part_mask = '0;
                s_idx     = '0;
                e_idx     = '0;
            end
        endcase
    end

    // Form the (possibly wrapping) run of selected bits inside the partition
    always_comb begin
        tail_mask = (part_mask >> e_idx) >> 1;
        sel_mask  = part_mask >> s_idx;
        if (s_idx <= e_idx) begin
            sel_mask = sel_mask ^ tail_mask;
        end else begin
            sel_mask = sel_mask | ~tail_mask;
        end
        sel_mask = sel_mask & part_mask;
    end

    // Bits of the old destination to retain; outside the partition always kept
    always_comb begin
        if (zero_rest) begin
            keep_mask = ~part_mask;
        end else begin
            keep_mask = ~sel_mask | ~part_mask;
        end
    end

endmodule

// File: rtl/rotins_merge.sv
// Module: rotins_merge
// Merges rotated source and old destination, and classifies the result.
// Assumes sel_mask and keep_mask do not overlap inside the partition.
module rotins_merge
    import rotins_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] rotated,
    input  logic [DATA_W-1:0] dst_old,
    input  logic [DATA_W-1:0] sel_mask,
    input  logic [DATA_W-1:0] keep_mask,
    output logic [DATA_W-1:0] merged,
    output ccode_e            cc_code
);

    // Combine inserted and retained bits
    always_comb begin
        merged = (rotated & sel_mask) | (dst_old & keep_mask);
    end

    // Signed classification of the merged word
    always_comb begin
        if (merged == '0) begin
            cc_code = CC_ZERO;
        end else if (merged[DATA_W-1]) begin
            cc_code = CC_NEG;
        end else begin
            cc_code = CC_POS;
        end
    end

endmodule

// File: rtl/rotins_unit.sv
// Module: rotins_unit (top)
// One-cycle rotate-then-insert unit for full, upper-half and lower-half
// variants. Assumes the caller holds inputs stable around the clock edge.
// Result and condition code load only on accepted requests.
module rotins_unit
    import rotins_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        opcode,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst_old,
    input  logic [IMM_W-1:0]  imm_start,
    input  logic [IMM_W-1:0]  imm_end,
    input  logic [IMM_W-1:0]  imm_rot,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [1:0]        cc,
    output logic              cc_valid,
    output logic              illegal_op
);

    variant_e          variant;
    logic [DATA_W-1:0] rotated;
    logic [DATA_W-1:0] sel_mask;
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] merged;
    ccode_e            cc_code;
    logic              unused_imm_bits;

    assign variant = decode_op(opcode);

    // Immediate bits above the index width carry no meaning (except the flag)
    assign unused_imm_bits = ^{imm_start[IMM_W-1:IDX_W],
                               imm_end[IMM_W-2:IDX_W],
                               imm_rot[IMM_W-1:IDX_W]};

    rotins_rotator #(.DATA_W(DATA_W)) rot_i (
        .din  (src),
        .amt  (imm_rot[IDX_W-1:0]),
        .dout (rotated)
    );

    rotins_maskgen #(.DATA_W(DATA_W)) mask_i (
        .variant   (variant),
        .start_idx (imm_start[IDX_W-1:0]),
        .end_idx   (imm_end[IDX_W-1:0]),
        .zero_rest (imm_end[IMM_W-1]),
        .sel_mask  (sel_mask),
        .keep_mask (keep_mask)
    );

    rotins_merge #(.DATA_W(DATA_W)) merge_i (
        .rotated   (rotated),
        .dst_old   (dst_old),
        .sel_mask  (sel_mask),
        .keep_mask (keep_mask),
        .merged    (merged),
        .cc_code   (cc_code)
    );

    // Output strobes follow the request by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            cc_valid   <= 1'b0;
            illegal_op <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            cc_valid   <= in_valid && (variant == VAR_FULL);
            illegal_op <= in_valid && (variant == VAR_NONE);
        end
    end

    // Result register loads only on an accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (in_valid) begin
            result <= merged;
        end
    end

    // Condition code loads only for the full-width variant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc <= 2'd0;
        end else if (in_valid && (variant == VAR_FULL)) begin
            cc <= cc_code;
        end
    end

endmodule

// File: rtl/rotins_unit_checker.sv
// Module: rotins_unit_checker
// Temporal properties of rotins_unit, bound to every instance of it.
// Assumes the default opcode byte values from rotins_pkg.
module rotins_unit_checker
    import rotins_pkg::*;
#(
    parameter int DATA_W = 64,
    localparam int HALF  = DATA_W / 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [7:0]        opcode,
    input logic [DATA_W-1:0] dst_old,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic [1:0]        cc,
    input logic              cc_valid,
    input logic              illegal_op
);

    logic is_known;
    assign is_known = (opcode == OP_FULL) || (opcode == OP_HIGH) || (opcode == OP_LOW);

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r6_low_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_HIGH) |=> result[HALF-1:0] == $past(dst_old[HALF-1:0]));

    a_r7_high_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_LOW) |=> result[DATA_W-1:HALF] == $past(dst_old[DATA_W-1:HALF]));

    a_r9_cc_class: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opcode == OP_FULL) |=>
            cc_valid && ((cc == 2'd0) == (result == '0)) && ((cc == 2'd1) == result[DATA_W-1]));

    a_r10_cc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opcode == OP_HIGH || opcode == OP_LOW)) |=> !cc_valid && $stable(cc));

    a_r11_illegal_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_known) |=> illegal_op && !cc_valid && result == $past(dst_old));

    a_r11_illegal_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> out_valid);

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(cc));

endmodule

bind rotins_unit rotins_unit_checker #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .opcode     (opcode),
    .dst_old    (dst_old),
    .out_valid  (out_valid),
    .result     (result),
    .cc         (cc),
    .cc_valid   (cc_valid),
    .illegal_op (illegal_op)
);

// File: tb/rotins_unit_tb_top.sv
// Bench: sweeps every start/end pair per variant, all rotate codes and all
// opcodes against a per-position model of the requirements.
module rotins_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [63:0] src = '0;
    logic [63:0] dst_old = '0;
    logic [7:0]  imm_start = '0;
    logic [7:0]  imm_end = '0;
    logic [7:0]  imm_rot = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [1:0]  cc;
    logic        cc_valid;
    logic        illegal_op;

    int n_checks = 0;
    int n_fails  = 0;
    logic [1:0] exp_cc = 2'd0;

    always #10 clk = ~clk;

    rotins_unit dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .opcode     (opcode),
        .src        (src),
        .dst_old    (dst_old),
        .imm_start  (imm_start),
        .imm_end    (imm_end),
        .imm_rot    (imm_rot),
        .out_valid  (out_valid),
        .result     (result),
        .cc         (cc),
        .cc_valid   (cc_valid),
        .illegal_op (illegal_op)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Per-position model: position p is word bit 63-p
    function automatic logic [63:0] model(input logic [7:0] op, input logic [63:0] s_w,
                                          input logic [63:0] d_w, input logic [7:0] st,
                                          input logic [7:0] en, input logic [7:0] ro);
        logic [63:0] rs;
        logic [63:0] res;
        int r = ro % 64;
        int lo, hi, s, e;
        rs = (r == 0) ? s_w : ((s_w << r) | (s_w >> (64 - r)));
        if (op == 8'h55) begin lo = 0;  hi = 63; s = st % 64; e = en % 64; end
        else if (op == 8'h5D) begin lo = 0;  hi = 31; s = st % 32; e = en % 32; end
        else if (op == 8'h51) begin lo = 32; hi = 63; s = st % 32; e = en % 32; end
        else return d_w;
        res = d_w;
        for (int p = lo; p <= hi; p++) begin
            int rel = p - lo;
            bit pick = (s <= e) ? (rel >= s && rel <= e) : (rel >= s || rel <= e);
            if (pick)       res[63-p] = rs[63-p];
            else if (en[7]) res[63-p] = 1'b0;
        end
        return res;
    endfunction

    function automatic logic [1:0] classify(input logic [63:0] v);
        if (v == 64'd0) return 2'd0;
        if (v[63])      return 2'd1;
        return 2'd2;
    endfunction

    // Issue one request, check the outputs, then check an idle cycle
    task automatic run_op(input logic [7:0] op, input logic [63:0] s_w, input logic [63:0] d_w,
                          input logic [7:0] st, input logic [7:0] en, input logic [7:0] ro,
                          input string req);
        logic [63:0] exp;
        logic        full;
        logic        known;
        exp   = model(op, s_w, d_w, st, en, ro);
        full  = (op == 8'h55);
        known = full || op == 8'h5D || op == 8'h51;
        if (full) exp_cc = classify(exp);
        @(negedge clk);
        in_valid = 1'b1; opcode = op; src = s_w; dst_old = d_w;
        imm_start = st; imm_end = en; imm_rot = ro;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " R1 out_valid"}, 64'(out_valid), 64'd1);
        check(req, result, exp);
        check(full ? "R9 cc" : "R10 cc unchanged", 64'(cc), 64'(exp_cc));
        check(full ? "R9 cc_valid" : "R10 cc_valid", 64'(cc_valid), 64'(full));
        check("R11 illegal_op", 64'(illegal_op), 64'(!known));
        @(negedge clk);
        check("R1 out_valid idle", 64'(out_valid), 64'd0);
        check("R12 result hold", result, exp);
        check("R12 cc hold", 64'(cc), 64'(exp_cc));
    endtask

    initial begin
        logic [7:0] ops [3] = '{8'h55, 8'h5D, 8'h51};
        repeat (3) @(negedge clk);
        check("R1 reset out_valid", 64'(out_valid), 64'd0);
        check("R1 reset result", result, 64'd0);
        check("R1 reset cc", 64'(cc), 64'd0);
        check("R1 reset cc_valid", 64'(cc_valid), 64'd0);
        check("R1 reset illegal_op", 64'(illegal_op), 64'd0);
        rst_n = 1'b1;

        // R2: full-width pass of the rotated source for every rotate code
        for (int ro = 0; ro < 256; ro++) begin
            run_op(8'h55, {$random, $random}, {$random, $random}, 8'd0, 8'd63, 8'(ro), "R2 rotate");
        end

        // R3/R4/R5/R6/R7/R8: every start/end pair, both flag settings
        for (int oi = 0; oi < 3; oi++) begin
            for (int s = 0; s < 64; s++) begin
                for (int e = 0; e < 64; e++) begin
                    for (int z = 0; z < 2; z++) begin
                        logic [63:0] sw;
                        logic [7:0]  st;
                        logic [7:0]  en;
                        string       tag;
                        int          lim;
                        lim = (oi == 0) ? 64 : 32;
                        sw  = ((s + e) % 7 == 0) ? 64'd0 : {$random, $random};
                        st  = 8'(s) | (8'($random) & 8'hC0);
                        en  = 8'(e) | (z ? 8'h80 : 8'h00) | (8'($random) & 8'h40);
                        tag = (oi == 0) ? "R5" : (oi == 1) ? "R6" : "R7";
                        tag = {tag, ((s % lim) <= (e % lim)) ? " R3" : " R4", z ? " R8 clear" : " R8 keep"};
                        run_op(ops[oi], sw, {$random, $random}, st, en, 8'($random), tag);
                    end
                end
            end
        end

        // R11: every unknown opcode passes the destination through
        for (int op = 0; op < 256; op++) begin
            if (op != 8'h55 && op != 8'h5D && op != 8'h51) begin
                run_op(8'(op), {$random, $random}, {$random, $random},
                       8'($random), 8'($random), 8'($random), "R11 pass-through");
            end
        end

        // R1: reset wins over a pending request
        @(negedge clk);
        in_valid = 1'b1; opcode = 8'h55; src = 64'hFFFF_0000_1234_5678;
        dst_old = 64'h1; imm_start = 8'd0; imm_end = 8'd63; imm_rot = 8'd4;
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 reset during request out_valid", 64'(out_valid), 64'd0);
        check("R1 reset during request result", result, 64'd0);
        check("R1 reset during request cc", 64'(cc), 64'd0);
        rst_n = 1'b1;
        exp_cc = 2'd0;
        run_op(8'h51, 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd8, 8'd3, 8'd0, "R7 R4 after reset");

        finish_run();
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule